// File: doc/BRIEF.md
# Deferred-Commit Memory Page Mapper

This block sits between a small 8-bit CPU and its memories. It splits the CPU's 256-byte logical space into four regions. A 128-byte ROM window and a 64-byte RAM window are each steered by a page number. A second stretch of RAM is always mapped, because it holds the machine state and the stack. The top eight bytes select hardware registers. The physical side has 32 KB of ROM (15 address bits) and 16 KB of RAM (14 address bits).

Software picks a page by writing one of two page registers in the register area. Such a write only loads a pending copy. The mapping in use does not change at that point. Both pending copies move into the active registers on the clock edge where the CPU raises its jump strobe. Code therefore keeps fetching from the old bank until control actually transfers, and the jump lands in the new bank.

Top module: `deferred_page_mapper`

## Requirements
- R1: After reset, both pending and both active pages are 0. Logical 0x05 then gives ROM address 0x0005, and both page registers read back 0.
- R2: For every logical address exactly one select is high: `rom_cs` for 0x00–0x7F, `ram_cs` for 0x80–0xF7, and `io_cs` for 0xF8–0xFF.
- R3: For 0x00–0x7F, `rom_addr` = active ROM page × 128 + (address mod 128).
- R4: For 0x80–0xBF, `ram_addr` = active RAM page × 64 + (address − 0x80).
- R5: For 0xC0–0xF7, `ram_addr` = 0xFF × 64 + (address − 0xC0), whatever the page settings are.
- R6: A write with `cpu_we` high to 0xF8 loads the pending ROM page, and a write to 0xF9 loads the pending RAM page. While the address is 0xF8 or 0xF9, `reg_rdata` shows that pending value. It is 0 at every other address. Writes to any other address leave both pending pages unchanged.
- R7: A page-register write without a jump leaves the active mapping unchanged.
- R8: A cycle with `jump_strobe` high copies both pending pages into the active pages on that clock edge.
- R9: When a page-register write and `jump_strobe` fall in the same cycle, the written value becomes active on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 8 | CPU logical address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| jump_strobe | input | 1 | High for one cycle when the CPU jumps; commits the pending pages |
| rom_addr | output | 15 | Physical ROM address |
| ram_addr | output | 14 | Physical RAM address |
| rom_cs | output | 1 | ROM select |
| ram_cs | output | 1 | RAM select |
| io_cs | output | 1 | Hardware-register select |
| reg_rdata | output | 8 | Read-back of the addressed pending page register |

## Verification
The hardest case to reach is a pending value that differs from the active one, combined with a page write that coincides with a jump. Only that combination tells "commit the old pending value" apart from "commit the freshly written value".

The stimulus first writes both pages without a jump and sweeps the full address range, so the old mapping has to persist. It then jumps and sweeps again. Next it issues one write together with a jump while the other pending page is left alone. Finally it runs writes to non-register addresses, followed by a jump, to show they had no effect. Sweeps over boundary page values (0x00, 0x01, 0x7F, 0x80, 0xFE, 0xFF) cover every address each time.

// File: rtl/pmap_pkg.sv
package pmap_pkg;

  localparam int CPU_AW    = 8;
  localparam int ROM_OFF_W = 7;
  localparam int RAM_OFF_W = 6;

  localparam logic [CPU_AW-1:0] BANK_RAM_LO  = 8'h80;
  localparam logic [CPU_AW-1:0] FIXED_RAM_LO = 8'hC0;
  localparam logic [CPU_AW-1:0] IO_LO        = 8'hF8;
  localparam logic [CPU_AW-1:0] ROM_PG_ADDR  = 8'hF8;
  localparam logic [CPU_AW-1:0] RAM_PG_ADDR  = 8'hF9;

  typedef enum logic [1:0] {
    RG_ROM       = 2'd0,
    RG_RAM_BANK  = 2'd1,
    RG_RAM_FIXED = 2'd2,
    RG_IO        = 2'd3
  } region_e;

  function automatic region_e classify(logic [CPU_AW-1:0] a);
    if (a < BANK_RAM_LO)       return RG_ROM;
    else if (a < FIXED_RAM_LO) return RG_RAM_BANK;
    else if (a < IO_LO)        return RG_RAM_FIXED;
    else                       return RG_IO;
  endfunction

  // Offset inside the always-mapped RAM stretch
  function automatic logic [RAM_OFF_W-1:0] fixed_offset(logic [CPU_AW-1:0] a);
    logic [CPU_AW-1:0] d;
    d = a - FIXED_RAM_LO;
    return d[RAM_OFF_W-1:0];
  endfunction

endpackage

// File: rtl/pmap_region_decode.sv
module pmap_region_decode
  import pmap_pkg::*;
(
  input  logic [CPU_AW-1:0] addr,
  output region_e           region,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic              io_cs,
  output logic              rom_pg_sel,
  output logic              ram_pg_sel
);

  always_comb begin
    region     = classify(addr);
    rom_cs     = (region == RG_ROM);
    ram_cs     = (region == RG_RAM_BANK) || (region == RG_RAM_FIXED);
    io_cs      = (region == RG_IO);
    rom_pg_sel = (addr == ROM_PG_ADDR);
    ram_pg_sel = (addr == RAM_PG_ADDR);
  end

endmodule

// File: rtl/pmap_commit_reg.sv
module pmap_commit_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         commit,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] active_q,
  output logic [W-1:0] commit_val
);

  // A write in the commit cycle bypasses the pending copy
  assign commit_val = wr_en ? wr_data : pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      active_q <= '0;
    end else begin
      if (wr_en)  pend_q   <= wr_data;
      if (commit) active_q <= commit_val;
    end
  end

endmodule

// File: rtl/pmap_phys_gen.sv
module pmap_phys_gen
  import pmap_pkg::*;
#(
  parameter int ROM_PAGE_W = 8,
  parameter int RAM_PAGE_W = 8,
  localparam int ROM_AW = ROM_PAGE_W + ROM_OFF_W,
  localparam int RAM_AW = RAM_PAGE_W + RAM_OFF_W
) (
  input  region_e               region,
  input  logic [ROM_PAGE_W-1:0] rom_pg,
  input  logic [RAM_PAGE_W-1:0] ram_pg,
  input  logic [ROM_OFF_W-1:0]  rom_off,
  input  logic [RAM_OFF_W-1:0]  ram_off,
  input  logic [RAM_OFF_W-1:0]  fix_off,
  output logic [ROM_AW-1:0]     rom_addr,
  output logic [RAM_AW-1:0]     ram_addr
);

  localparam logic [RAM_PAGE_W-1:0] RESV_BANK = '1;

  always_comb begin
    rom_addr = {rom_pg, rom_off};
    if (region == RG_RAM_FIXED) ram_addr = {RESV_BANK, fix_off};
    else                        ram_addr = {ram_pg, ram_off};
  end

endmodule

// File: rtl/deferred_page_mapper.sv
module deferred_page_mapper
  import pmap_pkg::*;
#(
  parameter int ROM_PAGE_W = 8,
  parameter int RAM_PAGE_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [CPU_AW-1:0]               cpu_addr,
  input  logic [CPU_AW-1:0]               cpu_wdata,
  input  logic                            cpu_we,
  input  logic                            jump_strobe,
  output logic [ROM_PAGE_W+ROM_OFF_W-1:0] rom_addr,
  output logic [RAM_PAGE_W+RAM_OFF_W-1:0] ram_addr,
  output logic                            rom_cs,
  output logic                            ram_cs,
  output logic                            io_cs,
  output logic [CPU_AW-1:0]               reg_rdata
);

  region_e               region;
  logic                  rom_pg_sel, ram_pg_sel;
  logic                  rom_wr_hit, ram_wr_hit;
  logic [ROM_PAGE_W-1:0] pend_rom_pg, active_rom_pg, rom_commit_val;
  logic [RAM_PAGE_W-1:0] pend_ram_pg, active_ram_pg, ram_commit_val;
  logic [RAM_OFF_W-1:0]  fix_off;

  pmap_region_decode u_dec (
    .addr       (cpu_addr),
    .region     (region),
    .rom_cs     (rom_cs),
    .ram_cs     (ram_cs),
    .io_cs      (io_cs),
    .rom_pg_sel (rom_pg_sel),
    .ram_pg_sel (ram_pg_sel)
  );

  assign rom_wr_hit = cpu_we && rom_pg_sel;
  assign ram_wr_hit = cpu_we && ram_pg_sel;

  pmap_commit_reg #(.W(ROM_PAGE_W)) u_rom_pg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (rom_wr_hit),
    .wr_data    (cpu_wdata[ROM_PAGE_W-1:0]),
    .commit     (jump_strobe),
    .pend_q     (pend_rom_pg),
    .active_q   (active_rom_pg),
    .commit_val (rom_commit_val)
  );

  pmap_commit_reg #(.W(RAM_PAGE_W)) u_ram_pg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ram_wr_hit),
    .wr_data    (cpu_wdata[RAM_PAGE_W-1:0]),
    .commit     (jump_strobe),
    .pend_q     (pend_ram_pg),
    .active_q   (active_ram_pg),
    .commit_val (ram_commit_val)
  );

  assign fix_off = fixed_offset(cpu_addr);

  pmap_phys_gen #(.ROM_PAGE_W(ROM_PAGE_W), .RAM_PAGE_W(RAM_PAGE_W)) u_phys (
    .region   (region),
    .rom_pg   (active_rom_pg),
    .ram_pg   (active_ram_pg),
    .rom_off  (cpu_addr[ROM_OFF_W-1:0]),
    .ram_off  (cpu_addr[RAM_OFF_W-1:0]),
    .fix_off  (fix_off),
    .rom_addr (rom_addr),
    .ram_addr (ram_addr)
  );

  always_comb begin
    reg_rdata = '0;
    if (rom_pg_sel)      reg_rdata = CPU_AW'(pend_rom_pg);
    else if (ram_pg_sel) reg_rdata = CPU_AW'(pend_ram_pg);
  end

endmodule

// File: rtl/pmap_checker.sv
module pmap_checker
  import pmap_pkg::*;
#(
  parameter int ROM_PAGE_W = 8,
  parameter int RAM_PAGE_W = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [CPU_AW-1:0]               cpu_addr,
  input logic [CPU_AW-1:0]               cpu_wdata,
  input logic                            cpu_we,
  input logic                            jump_strobe,
  input logic [ROM_PAGE_W+ROM_OFF_W-1:0] rom_addr,
  input logic [RAM_PAGE_W+RAM_OFF_W-1:0] ram_addr,
  input logic                            rom_cs,
  input logic                            ram_cs,
  input logic                            io_cs,
  input logic [ROM_PAGE_W-1:0]           pend_rom_pg,
  input logic [ROM_PAGE_W-1:0]           active_rom_pg,
  input logic [RAM_PAGE_W-1:0]           pend_ram_pg,
  input logic [RAM_PAGE_W-1:0]           active_ram_pg
);

  logic rom_wr, ram_wr;
  assign rom_wr = cpu_we && (cpu_addr == ROM_PG_ADDR);
  assign ram_wr = cpu_we && (cpu_addr == RAM_PG_ADDR);

  // R2
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rom_cs, ram_cs, io_cs}) == 1);

  // R2
  io_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= IO_LO) |-> io_cs);

  // R3
  rom_xlate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> (rom_addr[ROM_OFF_W-1:0] == cpu_addr[ROM_OFF_W-1:0]) &&
               (rom_addr[ROM_PAGE_W+ROM_OFF_W-1:ROM_OFF_W] == active_rom_pg));

  // R5
  fixed_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= FIXED_RAM_LO && cpu_addr < IO_LO) |->
      ram_cs && (&ram_addr[RAM_PAGE_W+RAM_OFF_W-1:RAM_OFF_W]));

  // R7
  rom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !jump_strobe |=> $stable(active_rom_pg));

  // R7
  ram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !jump_strobe |=> $stable(active_ram_pg));

  // R8
  rom_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_strobe && !rom_wr) |=> active_rom_pg == $past(pend_rom_pg));

  // R8
  ram_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_strobe && !ram_wr) |=> active_ram_pg == $past(pend_ram_pg));

  // R9
  rom_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_strobe && rom_wr) |=> active_rom_pg == $past(cpu_wdata[ROM_PAGE_W-1:0]));

  // R9
  ram_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_strobe && ram_wr) |=> active_ram_pg == $past(cpu_wdata[RAM_PAGE_W-1:0]));

endmodule

bind deferred_page_mapper pmap_checker #(
  .ROM_PAGE_W(ROM_PAGE_W),
  .RAM_PAGE_W(RAM_PAGE_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_addr      (cpu_addr),
  .cpu_wdata     (cpu_wdata),
  .cpu_we        (cpu_we),
  .jump_strobe   (jump_strobe),
  .rom_addr      (rom_addr),
  .ram_addr      (ram_addr),
  .rom_cs        (rom_cs),
  .ram_cs        (ram_cs),
  .io_cs         (io_cs),
  .pend_rom_pg   (pend_rom_pg),
  .active_rom_pg (active_rom_pg),
  .pend_ram_pg   (pend_ram_pg),
  .active_ram_pg (active_ram_pg)
);

// File: tb/deferred_page_mapper_bench.sv
module deferred_page_mapper_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cpu_addr = 8'h00;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_we = 1'b0;
  logic        jump_strobe = 1'b0;
  logic [14:0] rom_addr;
  logic [13:0] ram_addr;
  logic        rom_cs, ram_cs, io_cs;
  logic [7:0]  reg_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Bench model of the page state
  int m_pend_rom = 0, m_pend_ram = 0, m_act_rom = 0, m_act_ram = 0;

  always #10 clk = ~clk;

  deferred_page_mapper u_deferred_page_mapper (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .cpu_we      (cpu_we),
    .jump_strobe (jump_strobe),
    .rom_addr    (rom_addr),
    .ram_addr    (ram_addr),
    .rom_cs      (rom_cs),
    .ram_cs      (ram_cs),
    .io_cs       (io_cs),
    .reg_rdata   (reg_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Check one logical address against arithmetic expectations
  task automatic probe(input int a, input int exp_rom_pg, input int exp_ram_pg);
    int cs_exp, cs_act;
    @(negedge clk);
    cpu_addr = 8'(a);
    #2;
    cs_exp = (a < 128) ? 4 : (a < 248) ? 2 : 1;
    cs_act = {29'd0, rom_cs, ram_cs, io_cs};
    check(cs_act == cs_exp, "R2", cs_act, cs_exp);
    if (a < 128)
      check(int'(rom_addr) == exp_rom_pg * 128 + a % 128, "R3",
            int'(rom_addr), exp_rom_pg * 128 + a % 128);
    else if (a < 192)
      check(int'(ram_addr) == exp_ram_pg * 64 + (a - 128), "R4",
            int'(ram_addr), exp_ram_pg * 64 + (a - 128));
    else if (a < 248)
      check(int'(ram_addr) == 255 * 64 + (a - 192), "R5",
            int'(ram_addr), 255 * 64 + (a - 192));
    else begin
      int rb;
      rb = (a == 248) ? m_pend_rom : (a == 249) ? m_pend_ram : 0;
      check(int'(reg_rdata) == rb, "R6", int'(reg_rdata), rb);
    end
  endtask

  task automatic sweep(input int exp_rom_pg, input int exp_ram_pg);
    for (int a = 0; a < 256; a++) probe(a, exp_rom_pg, exp_ram_pg);
  endtask

  // One bus cycle; updates the bench model at the edge it covers
  task automatic bus(input int a, input int d, input bit we, input bit jmp);
    @(negedge clk);
    cpu_addr = 8'(a); cpu_wdata = 8'(d); cpu_we = we; jump_strobe = jmp;
    @(negedge clk);
    if (we && a == 248) m_pend_rom = d;
    if (we && a == 249) m_pend_ram = d;
    if (jmp) begin m_act_rom = m_pend_rom; m_act_ram = m_pend_ram; end
    cpu_we = 1'b0; jump_strobe = 1'b0;
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pages[6] = '{0, 1, 127, 128, 254, 255};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk); cpu_addr = 8'h05; #2;
    check(rom_addr == 15'h0005, "R1", int'(rom_addr), 5);
    cpu_addr = 8'hF8; #2;
    check(reg_rdata == 8'h00, "R1", int'(reg_rdata), 0);
    cpu_addr = 8'hF9; #2;
    check(reg_rdata == 8'h00, "R1", int'(reg_rdata), 0);
    sweep(0, 0);

    // R7: pending writes without jump; mapping stays at page 0, readback new
    bus(248, 8'h5A, 1'b1, 1'b0);
    bus(249, 8'h33, 1'b1, 1'b0);
    sweep(0, 0);

    // R8: jump commits both
    bus(0, 0, 1'b0, 1'b1);
    sweep(8'h5A, 8'h33);

    // R9: write and jump in the same cycle; RAM page keeps its pending value
    bus(248, 8'hC3, 1'b1, 1'b1);
    sweep(8'hC3, 8'h33);
    bus(249, 8'h0E, 1'b1, 1'b1);
    sweep(8'hC3, 8'h0E);

    // R6: writes outside the page registers have no effect
    bus(250, 8'h77, 1'b1, 1'b0);
    bus(255, 8'h66, 1'b1, 1'b0);
    bus(16,  8'h11, 1'b1, 1'b0);
    bus(144, 8'h22, 1'b1, 1'b0);
    bus(200, 8'h44, 1'b1, 1'b0);
    bus(0, 0, 1'b0, 1'b1);
    sweep(8'hC3, 8'h0E);

    // R3/R4/R5 over boundary page values, pages crossed
    foreach (pages[i]) begin
      bus(248, pages[i], 1'b1, 1'b0);
      bus(249, pages[5 - i], 1'b1, 1'b0);
      probe(3, m_act_rom, m_act_ram);   // R7: still old mapping
      bus(0, 0, 1'b0, 1'b1);
      sweep(pages[i], pages[5 - i]);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule